// File: doc/BRIEF.md
# Deep-Pipeline Branch and Load Hazard Controller

This block decides, every cycle, which stages of an eight-stage in-order integer pipeline must keep their contents and which must discard them. The stages, oldest last, are fetch-start, fetch-end, decode/register-read, execute, data-access-start, data-access-end, tag-check and write-back; they are numbered 0 to 7 in that order, and every stage mask on the ports uses that bit numbering. The controller looks at the instruction in decode, the instruction in execute and the memory operation in tag-check. It also remembers on its own which load has moved on into the first data-access stage. From these it produces a hold mask and a kill mask.

Three static policies for conditional branches are available, chosen at build time. In the first, the front end always drains. In the second, the front end fetches from the branch target. In the third, it fetches down the sequential path. Conditions resolve in execute, and an unconditional jump's target is known once the jump leaves decode. A consumer of a load waits until the load has reached the end of its data access, so that the value can be forwarded. A tag-check miss backs the whole pipe up by one cycle so the access can be replayed. Two running totals, of stall cycles and of killed slots, make the cost of each policy visible.

Top module: `deep_pipe_hazard_ctrl`

## Requirements
- R1: While reset is active, and in the first cycles after release with idle inputs, the hold mask and kill mask are zero and both counters read zero.
- R2: A valid jump in decode kills stages 1 and 0 (mask 8'h03), for a penalty of 2, under every policy. This happens only in a cycle where decode is not held and is not itself killed.
- R3: With the drain policy, a valid conditional branch in execute kills stages 2, 1 and 0 (8'h07), whether it is taken or not.
- R4: With the target-first policy, a taken branch kills stages 2 and 1 (8'h06) and a not-taken branch kills stages 2, 1 and 0 (8'h07).
- R5: With the sequential-first policy, a not-taken branch kills nothing and a taken branch kills stages 2, 1 and 0 (8'h07).
- R6: In the following cases decode holds with its sources matching a non-zero load destination, and hold is 8'h07 (stages 0 to 2), which puts a bubble into execute. The cases are a load in execute, or a load that was in execute at the previous advancing edge. A load two stages further ahead causes no hold. A consumer directly behind a load therefore waits 2 cycles, and one with a single instruction between them waits 1 cycle.
- R7: Register 0 is never a dependency: a load whose destination is 0 causes no hold.
- R8: A tag-check miss on a memory operation holds stages 0 to 6 (hold 8'h7F) for one cycle, with no kills, and defers branch, jump and load-use decisions to the next cycle. A miss reported in the cycle right after such a hold is ignored, because that cycle is the replay.
- R9: When a branch kills decode, the instruction there causes neither a load-use hold nor a jump kill.
- R10: The stall counter adds one for every cycle with a non-zero hold mask. The flush counter adds the number of set bits in the kill mask. Both wrap at 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released inside through a two-flop synchronizer |
| rf_valid_i | input | 1 | Decode stage holds an instruction |
| rf_jump_i | input | 1 | Decode instruction is an unconditional jump |
| rf_src_a_i | input | REG_AW | First source register of the decode instruction |
| rf_src_b_i | input | REG_AW | Second source register of the decode instruction |
| ex_valid_i | input | 1 | Execute stage holds an instruction |
| ex_cond_i | input | 1 | Execute instruction is a conditional branch |
| ex_taken_i | input | 1 | Resolved outcome of that branch |
| ex_load_i | input | 1 | Execute instruction is a load |
| ex_dst_i | input | REG_AW | Destination register of the execute instruction |
| tc_mem_i | input | 1 | Tag-check stage holds a memory operation |
| tc_miss_i | input | 1 | Tag check of that operation missed |
| hold_o | output | 8 | Per-stage hold mask, bit 0 = first fetch stage |
| kill_o | output | 8 | Per-stage kill mask, same numbering |
| stall_cnt_o | output | CNT_W | Running count of stall cycles |
| flush_cnt_o | output | CNT_W | Running count of killed stage slots |

## Verification
The hold and kill masks are due in the same cycle as the stage contents that cause them. The bench therefore drives each cycle's stage contents on the falling edge and compares both masks one nanosecond later, before the next rising edge. The one exception is the load shadow: it reflects the edge before, so a load that reaches the data stage affects the masks one cycle after it left execute. The bench follows this by moving its own pipeline model only after each comparison. The counters change at the rising edge after the cycle they count. The bench compares them with the totals of all earlier cycles, before it adds the current cycle.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

  localparam int NSTG  = 8;
  localparam int ST_IF = 0;
  localparam int ST_IS = 1;
  localparam int ST_RF = 2;
  localparam int ST_EX = 3;
  localparam int ST_DF = 4;
  localparam int ST_DS = 5;
  localparam int ST_TC = 6;
  localparam int ST_WB = 7;

  typedef enum logic [1:0] {
    SCH_FLUSH   = 2'd0,
    SCH_TAKEN   = 2'd1,
    SCH_UNTAKEN = 2'd2
  } br_scheme_e;

  typedef logic [NSTG-1:0] stg_mask_t;

  // Mask of `depth` stages counted downward (younger) from stage `top`.
  function automatic stg_mask_t young_mask(int unsigned top, int unsigned depth);
    stg_mask_t m;
    m = '0;
    for (int unsigned k = 0; k < NSTG; k++) begin
      if (k <= top && (top - k) < depth) m[k] = 1'b1;
    end
    return m;
  endfunction

  // Bubble count charged to a resolved conditional branch under a policy.
  function automatic int unsigned cond_penalty(br_scheme_e s, logic taken);
    int unsigned p;
    case (s)
      SCH_TAKEN:   p = taken ? 2 : 3;
      SCH_UNTAKEN: p = taken ? 3 : 0;
      default:     p = 3;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/hzc_rst_sync.sv
module hzc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hzc_branch_unit.sv
module hzc_branch_unit
  import hzc_pkg::*;
#(
  parameter br_scheme_e SCHEME = SCH_UNTAKEN
) (
  input  logic      resolve_en_i,
  input  logic      ex_valid_i,
  input  logic      ex_cond_i,
  input  logic      ex_taken_i,
  input  logic      rf_valid_i,
  input  logic      rf_jump_i,
  input  logic      rf_held_i,
  output stg_mask_t cond_kill_o,
  output logic      rf_squash_o,
  output stg_mask_t jump_kill_o
);
  localparam int unsigned PEN_JUMP  = 2;
  localparam int unsigned PEN_TAKEN = cond_penalty(SCHEME, 1'b1);
  localparam int unsigned PEN_NOT   = cond_penalty(SCHEME, 1'b0);
  localparam stg_mask_t   MASK_TAKEN = young_mask(ST_RF, PEN_TAKEN);
  localparam stg_mask_t   MASK_NOT   = young_mask(ST_RF, PEN_NOT);
  localparam stg_mask_t   MASK_JUMP  = young_mask(ST_IS, PEN_JUMP);

  always_comb begin
    cond_kill_o = '0;
    if (resolve_en_i && ex_valid_i && ex_cond_i) begin
      cond_kill_o = ex_taken_i ? MASK_TAKEN : MASK_NOT;
    end
  end

  assign rf_squash_o = cond_kill_o[ST_RF];

  always_comb begin
    jump_kill_o = '0;
    if (resolve_en_i && rf_valid_i && rf_jump_i && !rf_squash_o && !rf_held_i) begin
      jump_kill_o = MASK_JUMP;
    end
  end
endmodule

// File: rtl/hzc_load_interlock.sv
module hzc_load_interlock #(
  parameter int RAW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           advance_i,
  input  logic           ex_valid_i,
  input  logic           ex_load_i,
  input  logic [RAW-1:0] ex_dst_i,
  input  logic           rf_valid_i,
  input  logic [RAW-1:0] rf_src_a_i,
  input  logic [RAW-1:0] rf_src_b_i,
  input  logic           rf_squash_i,
  output logic           stall_o
);
  logic           df_ld_q, df_ld_d;
  logic [RAW-1:0] df_dst_q, df_dst_d;
  logic           hit_ex, hit_df;

  function automatic logic needs(logic v, logic [RAW-1:0] d,
                                 logic [RAW-1:0] a, logic [RAW-1:0] b);
    return v && (d != '0) && ((d == a) || (d == b));
  endfunction

  // Shadow of the load now in the first data-access stage.
  always_comb begin
    df_ld_d  = ex_valid_i && ex_load_i;
    df_dst_d = ex_dst_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      df_ld_q  <= 1'b0;
      df_dst_q <= '0;
    end else if (advance_i) begin
      df_ld_q  <= df_ld_d;
      df_dst_q <= df_dst_d;
    end
  end

  always_comb begin
    hit_ex  = needs(ex_valid_i && ex_load_i, ex_dst_i, rf_src_a_i, rf_src_b_i);
    hit_df  = needs(df_ld_q, df_dst_q, rf_src_a_i, rf_src_b_i);
    stall_o = rf_valid_i && !rf_squash_i && (hit_ex || hit_df);
  end

  // R7
  r0_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid_i && ex_load_i && ex_dst_i == '0 && !df_ld_q) |-> !stall_o);

  // R6
  stall_needs_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (rf_valid_i && !rf_squash_i));
endmodule

// File: rtl/hzc_counters.sv
module hzc_counters
  import hzc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_ev_i,
  input  stg_mask_t     kill_i,
  output logic [CW-1:0] stall_cnt_o,
  output logic [CW-1:0] flush_cnt_o
);
  localparam int KW = $clog2(NSTG + 1);

  logic [KW-1:0] kill_num;
  logic [CW-1:0] stall_q, stall_d, flush_q, flush_d;

  always_comb begin
    kill_num = '0;
    for (int k = 0; k < NSTG; k++) kill_num = kill_num + KW'(kill_i[k]);
    stall_d = stall_q + CW'(1);
    flush_d = flush_q + CW'(kill_num);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= '0;
      flush_q <= '0;
    end else begin
      if (stall_ev_i)  stall_q <= stall_d;
      if (|kill_i)     flush_q <= flush_d;
    end
  end

  assign stall_cnt_o = stall_q;
  assign flush_cnt_o = flush_q;

  // R10
  stall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stall_cnt_o == $past(stall_cnt_o) + CW'($past(stall_ev_i))));

  // R10
  flush_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(kill_i) == '0) |-> $stable(flush_cnt_o));
endmodule

// File: rtl/deep_pipe_hazard_ctrl.sv
module deep_pipe_hazard_ctrl
  import hzc_pkg::*;
#(
  parameter br_scheme_e SCHEME = SCH_UNTAKEN,
  parameter int         REG_AW = 5,
  parameter int         CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rf_valid_i,
  input  logic              rf_jump_i,
  input  logic [REG_AW-1:0] rf_src_a_i,
  input  logic [REG_AW-1:0] rf_src_b_i,
  input  logic              ex_valid_i,
  input  logic              ex_cond_i,
  input  logic              ex_taken_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] ex_dst_i,
  input  logic              tc_mem_i,
  input  logic              tc_miss_i,
  output logic [7:0]        hold_o,
  output logic [7:0]        kill_o,
  output logic [CNT_W-1:0]  stall_cnt_o,
  output logic [CNT_W-1:0]  flush_cnt_o
);
  localparam stg_mask_t MASK_MISS = young_mask(ST_TC, ST_TC + 1);
  localparam stg_mask_t MASK_LU   = young_mask(ST_RF, ST_RF + 1);

  logic      rst_sync_n;
  logic      replay_q, replay_d;
  logic      miss_take, resolve_en;
  logic      lu_stall, rf_squash;
  stg_mask_t cond_kill, jump_kill;

  hzc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // A miss backs the pipe up once; the following cycle is the replay.
  always_comb begin
    miss_take  = tc_mem_i && tc_miss_i && !replay_q;
    replay_d   = miss_take;
    resolve_en = !miss_take;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) replay_q <= 1'b0;
    else             replay_q <= replay_d;
  end

  hzc_branch_unit #(.SCHEME(SCHEME)) u_br (
    .resolve_en_i (resolve_en),
    .ex_valid_i   (ex_valid_i),
    .ex_cond_i    (ex_cond_i),
    .ex_taken_i   (ex_taken_i),
    .rf_valid_i   (rf_valid_i),
    .rf_jump_i    (rf_jump_i),
    .rf_held_i    (lu_stall),
    .cond_kill_o  (cond_kill),
    .rf_squash_o  (rf_squash),
    .jump_kill_o  (jump_kill)
  );

  hzc_load_interlock #(.RAW(REG_AW)) u_lu (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .advance_i   (resolve_en),
    .ex_valid_i  (ex_valid_i),
    .ex_load_i   (ex_load_i),
    .ex_dst_i    (ex_dst_i),
    .rf_valid_i  (rf_valid_i),
    .rf_src_a_i  (rf_src_a_i),
    .rf_src_b_i  (rf_src_b_i),
    .rf_squash_i (rf_squash),
    .stall_o     (lu_stall)
  );

  always_comb begin
    hold_o = '0;
    kill_o = '0;
    if (rst_sync_n) begin
      if (miss_take) begin
        hold_o = MASK_MISS;
      end else begin
        if (lu_stall) hold_o = MASK_LU;
        kill_o = cond_kill | jump_kill;
      end
    end
  end

  hzc_counters #(.CW(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .stall_ev_i  (|hold_o),
    .kill_i      (kill_o),
    .stall_cnt_o (stall_cnt_o),
    .flush_cnt_o (flush_cnt_o)
  );

  // R8
  miss_once_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(hold_o[ST_TC]) |=> !hold_o[ST_TC]);

  // R8
  miss_no_kill_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hold_o[ST_TC] |-> (kill_o == '0));

  // R9
  branch_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    kill_o[ST_RF] |-> !hold_o[ST_RF]);

  generate
    if (SCHEME == SCH_FLUSH) begin : g_drain
      // R3
      drain_all_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (ex_valid_i && ex_cond_i && !hold_o[ST_TC]) |-> (kill_o[2:0] == 3'b111));
    end else if (SCHEME == SCH_TAKEN) begin : g_target
      // R4
      target_keeps_if_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (ex_valid_i && ex_cond_i && ex_taken_i && !hold_o[ST_TC])
          |-> (kill_o[2:0] == 3'b110));
    end else begin : g_seq
      // R5
      seq_free_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (ex_valid_i && ex_cond_i && !ex_taken_i) |-> !kill_o[ST_RF]);
    end
  endgenerate
endmodule

// File: tb/tb_deep_pipe_hazard_ctrl.sv
`timescale 1ns/1ps

module hzc_lane #(
  parameter hzc_pkg::br_scheme_e SCHEME = hzc_pkg::SCH_FLUSH,
  parameter int CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   errors,
  output logic done
);
  typedef struct packed {
    logic       v, jmp, cnd, tkn, ld, mem, mis;
    logic [4:0] dst, sa, sb;
  } ins_t;

  localparam ins_t BUB = '0;

  logic       rf_valid, rf_jump, ex_valid, ex_cond, ex_taken, ex_load, tc_mem, tc_miss;
  logic [4:0] rf_sa, rf_sb, ex_dst;
  logic [7:0] hold, kill;
  logic [15:0] scnt, fcnt;

  deep_pipe_hazard_ctrl #(.SCHEME(SCHEME), .REG_AW(5), .CNT_W(16)) dut (
    .clk(clk), .rst_n(rst_n),
    .rf_valid_i(rf_valid), .rf_jump_i(rf_jump), .rf_src_a_i(rf_sa), .rf_src_b_i(rf_sb),
    .ex_valid_i(ex_valid), .ex_cond_i(ex_cond), .ex_taken_i(ex_taken),
    .ex_load_i(ex_load), .ex_dst_i(ex_dst),
    .tc_mem_i(tc_mem), .tc_miss_i(tc_miss),
    .hold_o(hold), .kill_o(kill), .stall_cnt_o(scnt), .flush_cnt_o(fcnt)
  );

  ins_t prog [32];
  ins_t pipe [8];

  function automatic ins_t mk(logic j, logic c, logic t, logic l, logic m, logic x,
                              int d, int a, int b);
    ins_t r;
    r = '0;
    r.v = 1'b1; r.jmp = j; r.cnd = c; r.tkn = t; r.ld = l; r.mem = m; r.mis = x;
    r.dst = 5'(d); r.sa = 5'(a); r.sb = 5'(b);
    return r;
  endfunction

  function automatic ins_t alu(int a, int b);
    return mk(0, 0, 0, 0, 0, 0, 9, a, b);
  endfunction

  function automatic logic [7:0] bmask(logic taken);
    case (SCHEME)
      hzc_pkg::SCH_TAKEN:   return taken ? 8'h06 : 8'h07;
      hzc_pkg::SCH_UNTAKEN: return taken ? 8'h07 : 8'h00;
      default:              return 8'h07;
    endcase
  endfunction

  function automatic logic dep(ins_t l, ins_t c);
    return l.v && l.ld && l.dst != 0 && c.v && (l.dst == c.sa || l.dst == c.sb);
  endfunction

  function automatic logic dep_r0(ins_t l, ins_t c);
    return l.v && l.ld && l.dst == 0 && c.v && (c.sa == 0 || c.sb == 0);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s (%s): actual %0h expected %0h", tag, what,
               SCHEME.name(), act, exp);
    end
  endtask

  task automatic drive();
    rf_valid = pipe[2].v;  rf_jump = pipe[2].v && pipe[2].jmp;
    rf_sa = pipe[2].sa;    rf_sb = pipe[2].sb;
    ex_valid = pipe[3].v;  ex_cond = pipe[3].cnd; ex_taken = pipe[3].tkn;
    ex_load = pipe[3].ld;  ex_dst = pipe[3].dst;
    tc_mem = pipe[6].v && pipe[6].mem; tc_miss = pipe[6].mis;
  endtask

  string stag;

  initial begin
    int pc;
    logic last_miss;
    int exp_stall, exp_flush;
    checks = 0; errors = 0; done = 1'b0;
    for (int k = 0; k < 8; k++) pipe[k] = BUB;
    for (int k = 0; k < 32; k++) prog[k] = alu(1, 2);
    prog[1]  = mk(0, 0, 0, 1, 1, 0, 5, 0, 0);
    prog[2]  = alu(5, 3);
    prog[3]  = mk(0, 0, 0, 1, 1, 0, 6, 0, 0);
    prog[5]  = alu(2, 6);
    prog[6]  = mk(0, 0, 0, 1, 1, 0, 0, 0, 0);
    prog[7]  = alu(0, 0);
    prog[8]  = mk(0, 1, 1, 0, 0, 0, 0, 1, 2);
    prog[12] = mk(0, 1, 0, 0, 0, 0, 0, 1, 2);
    prog[16] = mk(1, 0, 0, 0, 0, 0, 0, 0, 0);
    prog[19] = mk(0, 0, 0, 1, 1, 1, 7, 0, 0);
    prog[20] = alu(7, 1);
    prog[23] = mk(0, 0, 0, 1, 1, 0, 8, 0, 0);
    prog[24] = mk(0, 1, 1, 0, 0, 0, 0, 1, 2);
    prog[25] = alu(8, 8);
    prog[26] = mk(0, 0, 0, 0, 1, 1, 0, 3, 4);
    prog[28] = mk(0, 1, 1, 0, 0, 0, 0, 1, 2);
    prog[29] = mk(1, 0, 0, 0, 0, 0, 0, 0, 0);
    drive();
    pc = 0; last_miss = 1'b0; exp_stall = 0; exp_flush = 0;

    wait (rst_n === 1'b1);
    repeat (4) @(negedge clk);
    #1;
    // R1: idle after reset
    chk("R1", "hold", int'(hold), 0);
    chk("R1", "kill", int'(kill), 0);
    chk("R1", "stall count", int'(scnt), 0);
    chk("R1", "flush count", int'(fcnt), 0);

    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      logic miss, lu;
      logic [7:0] bk, jk, eh, ek;
      @(negedge clk);
      drive();
      #1;
      miss = pipe[6].v && pipe[6].mem && pipe[6].mis && !last_miss;
      eh = '0; ek = '0; lu = 1'b0; bk = '0; jk = '0;
      if (miss) begin
        eh = 8'h7F;
        stag = "R8";
      end else begin
        bk = (pipe[3].v && pipe[3].cnd) ? bmask(pipe[3].tkn) : 8'h00;
        lu = !bk[2] && (dep(pipe[3], pipe[2]) || dep(pipe[4], pipe[2]));
        jk = (pipe[2].v && pipe[2].jmp && !bk[2] && !lu) ? 8'h03 : 8'h00;
        eh = lu ? 8'h07 : 8'h00;
        ek = bk | jk;
        if (lu) stag = "R6";
        else if (dep_r0(pipe[3], pipe[2]) || dep_r0(pipe[4], pipe[2])) stag = "R7";
        else if (bk[2] && (pipe[2].jmp || dep(pipe[3], pipe[2]) || dep(pipe[4], pipe[2])))
          stag = "R9";
        else if (pipe[3].v && pipe[3].cnd)
          stag = (SCHEME == hzc_pkg::SCH_FLUSH) ? "R3" :
                 (SCHEME == hzc_pkg::SCH_TAKEN) ? "R4" : "R5";
        else if (jk != 0) stag = "R2";
        else stag = "R6";
      end
      chk(stag, "hold", int'(hold), int'(eh));
      chk(stag, "kill", int'(kill), int'(ek));
      // R10: totals of all earlier cycles
      chk("R10", "stall count", int'(scnt), exp_stall & 16'hFFFF);
      chk("R10", "flush count", int'(fcnt), exp_flush & 16'hFFFF);

      exp_stall += (eh != 0) ? 1 : 0;
      exp_flush += $countones(ek);
      if (miss) begin
        pipe[7] = BUB;
        last_miss = 1'b1;
      end else begin
        for (int k = 0; k < 8; k++) if (ek[k]) pipe[k] = BUB;
        if (lu) begin
          for (int k = 7; k >= 4; k--) pipe[k] = pipe[k-1];
          pipe[3] = BUB;
        end else begin
          for (int k = 7; k >= 1; k--) pipe[k] = pipe[k-1];
          pipe[0] = prog[pc];
          pc = (pc + 1) % 32;
        end
        last_miss = 1'b0;
      end
    end
    done = 1'b1;
  end
endmodule

module tb_deep_pipe_hazard_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   c0, c1, c2, e0, e1, e2;
  logic d0, d1, d2;

  always #2.5 clk = ~clk;

  hzc_lane #(.SCHEME(hzc_pkg::SCH_FLUSH))   u_drain  (.clk(clk), .rst_n(rst_n),
    .checks(c0), .errors(e0), .done(d0));
  hzc_lane #(.SCHEME(hzc_pkg::SCH_TAKEN))   u_target (.clk(clk), .rst_n(rst_n),
    .checks(c1), .errors(e1), .done(d1));
  hzc_lane #(.SCHEME(hzc_pkg::SCH_UNTAKEN)) u_seq    (.clk(clk), .rst_n(rst_n),
    .checks(c2), .errors(e2), .done(d2));

  initial begin
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int cyc;
    int wd;
    cyc = 0;
    wd  = 0;
    while (!(d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1) && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 20000) begin
      wd = 1;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", c0 + c1 + c2 + wd, e0 + e1 + e2 + wd);
    $finish;
  end
endmodule